// File: doc/BRIEF.md
# SPI Register Access Frame Controller

This block performs one register read or one register write on a serially controlled I/O device over a full-duplex SPI link. A host pulses `start` with a register address, a two-bit device select, a direction flag and a data byte. The controller then builds a command frame, lowers `cs_n`, and clocks the frame out on `mosi` while it collects the same number of bits from `miso`. When checking is enabled, a third byte carries a 5-bit CRC of the first two bytes, and the third byte received back is checked against a CRC computed over the response.

After the frame ends, the first byte received is always presented as a diagnostic byte. The second byte received is the register contents for a read and a second diagnostic byte for a write. If the response fails its CRC check, only the error flag changes. The link runs in SPI mode 0, most significant bit first. The SCLK half-period is a whole number of system clocks, set by a parameter.

The controller is a five-state machine:
- ST_IDLE moves to ST_LEAD on an accepted start.
- ST_LEAD lasts one half-period with `cs_n` low and `sclk` low, then moves to ST_SHIFT on the first rising edge.
- ST_SHIFT toggles `sclk` every half-period. It moves to ST_TRAIL on the falling edge that follows the last bit.
- ST_TRAIL holds one more half-period, then moves to ST_DONE, where the results are registered.
- ST_DONE raises `cs_n`, pulses `done`, and returns to ST_IDLE after one cycle.

Top module: `spi_regframe_ctrl`

## Requirements
- R1: After reset, `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0, `done`=0, `crc_err`=0, and `rdata`, `diag0` and `diag1` are all 0.
- R2: The first byte sent is {chip_addr[1:0], addr[4:0], rw}: device select in bits 7:6, register address in bits 5:1, direction in bit 0 (1 = write, 0 = read). The second byte sent is `wdata`. Every byte is sent MSB first.
- R3: A frame has 16 SCLK rising edges when `crc_en`=0 and 24 when `crc_en`=1. MISO is sampled on each rising edge, so the same number of bits is received as is sent.
- R4: With `crc_en`=1, the third byte sent is {3'b000, C}. C is a 5-bit CRC with seed 5'h1F and polynomial 5'h15. It is computed over all 16 bits of bytes 1 and 2, MSB first, followed by three 0 bits. Each step shifts the CRC left, and XORs in the polynomial when the incoming bit differs from the old bit 4.
- R5: Mode 0 timing applies:
  - `sclk` is low whenever `cs_n` is high.
  - `cs_n` stays low for the whole frame, with one half-period before the first rising edge and one after the last falling edge.
  - `mosi` changes only while `sclk` is low.
- R6: After a transaction that does not fail its CRC check, `diag0` holds the first received byte.
- R7: After a good write, `diag1` holds the second received byte and `rdata` is unchanged. After a good read, `rdata` holds the second received byte and `diag1` is unchanged. These outputs change only in the `done` cycle.
- R8: With `crc_en`=1, the response CRC uses the same seed and polynomial as R4. It is computed over the low 6 bits of received byte 1 and all of received byte 2, followed by three 0 bits. It is compared with bits 4:0 of received byte 3; bits 7:5 of that byte are ignored. On a mismatch, `crc_err`=1 and `rdata`, `diag0` and `diag1` keep their previous values.
- R9: `done` is a single-cycle pulse with `cs_n` already high. `busy` is high from the cycle after an accepted start through the `done` cycle.
- R10: A `start` while `busy` is high is ignored. This includes a `start` in the `done` cycle: no new frame begins and the frame in flight is unchanged.
- R11: `crc_err` is cleared by the next transaction that passes its check. It is never set when `crc_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| addr | input | 5 | Register address |
| chip_addr | input | 2 | Device select placed in the command byte |
| rw | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Data byte to write |
| crc_en | input | 1 | Append and check the CRC byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Register value from the last good read |
| diag0 | output | 8 | First response byte of the last good transaction |
| diag1 | output | 8 | Second response byte of the last good write |
| crc_err | output | 1 | Last checked response failed its CRC |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 1 | Device select, active low |

## Verification
Completion and acceptance of a new request can land in the same cycle. A `start` arriving in the `done` cycle must be dropped, because `busy` is still high then. The bench raises `start` with fresh inputs in exactly the cycle where `done` is seen. It then checks that `busy` falls, that `cs_n` stays high, and that the device model counts no extra frame. A second test raises `start` in the middle of a frame. It then compares the bits captured on `mosi` with the command taken at the original start.

// File: rtl/spi_regframe_pkg.sv
package spi_regframe_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 5;
    localparam logic [CRC_W-1:0] CRC_SEED = 5'h1F;
    localparam logic [CRC_W-1:0] CRC_POLY = 5'h15;
    localparam int CRC_TAIL = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_DONE
    } fsm_e;

    function automatic logic [CRC_W-1:0] crc5_next(input logic [CRC_W-1:0] s, input logic b);
        logic [CRC_W-1:0] sh;
        sh = {s[CRC_W-2:0], 1'b0};
        return (b ^ s[CRC_W-1]) ? (CRC_POLY ^ sh) : sh;
    endfunction

endpackage

// File: rtl/regframe_crc5.sv
module regframe_crc5
    import spi_regframe_pkg::*;
#(
    parameter int SKIP = 0
) (
    input  logic [2*BYTE_W-1:0] frame,
    output logic [CRC_W-1:0]    crc
);
    localparam int NBITS = 2*BYTE_W - SKIP;

    logic [CRC_W-1:0] acc;

    always_comb begin
        acc = CRC_SEED;
        for (int i = NBITS-1; i >= 0; i--) begin
            acc = crc5_next(acc, frame[i]);
        end
        for (int j = 0; j < CRC_TAIL; j++) begin
            acc = crc5_next(acc, 1'b0);
        end
        crc = acc;
    end

endmodule

// File: rtl/regframe_tick.sv
module regframe_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    generate
        if (HALF == 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!run || cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/regframe_shifter.sv
module regframe_shifter #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_val,
    input  logic               shift_out,
    input  logic               sample,
    input  logic               serial_in,
    output logic               serial_out,
    output logic [FRAME_W-1:0] rx_word
);
    logic [FRAME_W-1:0] tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_val;
        end else if (shift_out) begin
            tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (load) begin
            rx_word <= '0;
        end else if (sample) begin
            rx_word <= {rx_word[FRAME_W-2:0], serial_in};
        end
    end

    assign serial_out = tx_sr[FRAME_W-1];

endmodule

// File: rtl/spi_regframe_ctrl.sv
module spi_regframe_ctrl
    import spi_regframe_pkg::*;
#(
    parameter int CHIP_W   = 2,
    parameter int ADDR_W   = 5,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CHIP_W-1:0] chip_addr,
    input  logic              rw,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              crc_en,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] diag0,
    output logic [BYTE_W-1:0] diag1,
    output logic              crc_err,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int CMD_W    = CHIP_W + ADDR_W + 1;
    localparam int FRAME_W  = 3 * BYTE_W;
    localparam int SHORT_W  = 2 * BYTE_W;
    localparam int BCW      = $clog2(FRAME_W + 1);
    localparam logic [BCW-1:0] BITS_LONG  = BCW'(FRAME_W);
    localparam logic [BCW-1:0] BITS_SHORT = BCW'(SHORT_W);

    fsm_e state, nxt;

    logic              tick;
    logic              in_frame;
    logic              accept;
    logic              rise_ev;
    logic              fall_ev;
    logic              crc_en_q;
    logic              rw_q;
    logic [BCW-1:0]    bitcnt;
    logic [BCW-1:0]    last_bit;
    logic [CMD_W-1:0]  cmd_byte;
    logic [CRC_W-1:0]  crc_tx;
    logic [CRC_W-1:0]  crc_rx;
    logic [FRAME_W-1:0] tx_frame;
    logic [FRAME_W-1:0] rx_word;
    logic [FRAME_W-1:0] rx_norm;
    logic              tx_bit;
    logic              crc_ok;

    // command byte: device select high, register address, direction in bit 0
    assign cmd_byte = {chip_addr, addr, rw};

    regframe_crc5 #(.SKIP(0)) i_crc_enc (
        .frame ({cmd_byte, wdata}),
        .crc   (crc_tx)
    );

    assign tx_frame = {cmd_byte, wdata,
                       crc_en ? {{(BYTE_W-CRC_W){1'b0}}, crc_tx} : {BYTE_W{1'b0}}};

    assign in_frame = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TRAIL);
    assign accept   = (state == ST_IDLE) && start;
    assign rise_ev  = tick && ((state == ST_LEAD) || ((state == ST_SHIFT) && !sclk));
    assign fall_ev  = tick && (state == ST_SHIFT) && sclk;
    assign last_bit = crc_en_q ? BITS_LONG : BITS_SHORT;

    regframe_tick #(.HALF(HALF_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_frame),
        .tick  (tick)
    );

    regframe_shifter #(.FRAME_W(FRAME_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_val   (tx_frame),
        .shift_out  (fall_ev),
        .sample     (rise_ev),
        .serial_in  (miso),
        .serial_out (tx_bit),
        .rx_word    (rx_word)
    );

    // response aligned so byte 1 always sits in the top byte
    assign rx_norm = crc_en_q ? rx_word : {rx_word[SHORT_W-1:0], {BYTE_W{1'b0}}};

    regframe_crc5 #(.SKIP(2)) i_crc_dec (
        .frame (rx_norm[FRAME_W-1:BYTE_W]),
        .crc   (crc_rx)
    );

    assign crc_ok = !crc_en_q ||
                    ((rx_norm[BYTE_W-1:0] & BYTE_W'(8'h1F)) == {{(BYTE_W-CRC_W){1'b0}}, crc_rx});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_LEAD;
            ST_LEAD:  if (tick) nxt = ST_SHIFT;
            ST_SHIFT: if (fall_ev && bitcnt == last_bit) nxt = ST_TRAIL;
            ST_TRAIL: if (tick) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // frame bookkeeping and link clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk     <= 1'b0;
            bitcnt   <= '0;
            crc_en_q <= 1'b0;
            rw_q     <= 1'b0;
        end else begin
            if (accept) begin
                bitcnt   <= '0;
                crc_en_q <= crc_en;
                rw_q     <= rw;
            end
            if (rise_ev) begin
                sclk   <= 1'b1;
                bitcnt <= bitcnt + 1'b1;
            end else if (fall_ev) begin
                sclk <= 1'b0;
            end
        end
    end

    // host-side results, registered on the edge into ST_DONE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata   <= '0;
            diag0   <= '0;
            diag1   <= '0;
            crc_err <= 1'b0;
        end else if (state == ST_TRAIL && tick) begin
            crc_err <= !crc_ok;
            if (crc_ok) begin
                diag0 <= rx_norm[FRAME_W-1 -: BYTE_W];
                if (rw_q) begin
                    diag1 <= rx_norm[FRAME_W-BYTE_W-1 -: BYTE_W];
                end else begin
                    rdata <= rx_norm[FRAME_W-BYTE_W-1 -: BYTE_W];
                end
            end
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);
    assign cs_n = !in_frame;
    assign mosi = in_frame && tx_bit;

endmodule

// File: rtl/spi_regframe_chk.sv
module spi_regframe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [7:0] rdata,
    input logic [7:0] diag0,
    input logic [7:0] diag1,
    input logic       crc_err,
    input logic       sclk,
    input logic       mosi,
    input logic       cs_n
);
    assert_sclk_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_hold_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && cs_n));

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_start_at_done_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !busy);

    assert_rdata_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);

    assert_diag1_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(diag1) |-> done);

    assert_diag0_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(diag0) |-> done);

    assert_crc_err_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(crc_err) |-> done);

endmodule

bind spi_regframe_ctrl spi_regframe_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rdata   (rdata),
    .diag0   (diag0),
    .diag1   (diag1),
    .crc_err (crc_err),
    .sclk    (sclk),
    .mosi    (mosi),
    .cs_n    (cs_n)
);

// File: tb/test_spi_regframe_ctrl.sv
`timescale 1ns/1ps
module test_spi_regframe_ctrl;

    typedef struct packed {
        logic       crc_en;
        logic       rw;
        logic [1:0] chip;
        logic [4:0] addr;
        logic [7:0] wdata;
        logic [7:0] r0;
        logic [7:0] r1;
        logic [2:0] r2hi;
        logic       bad;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 2'd1, 5'h0A, 8'hA5, 8'h3C, 8'hC3, 3'b000, 1'b0},
        '{1'b0, 1'b0, 2'd2, 5'h1F, 8'h00, 8'h81, 8'h7E, 3'b000, 1'b0},
        '{1'b1, 1'b1, 2'd3, 5'h01, 8'h5A, 8'h12, 8'h34, 3'b101, 1'b0},
        '{1'b1, 1'b0, 2'd0, 5'h15, 8'hFF, 8'hF0, 8'h0F, 3'b000, 1'b0},
        '{1'b1, 1'b0, 2'd1, 5'h02, 8'h00, 8'hAA, 8'h55, 3'b000, 1'b1},
        '{1'b1, 1'b1, 2'd2, 5'h07, 8'h11, 8'h01, 8'h02, 3'b111, 1'b0},
        '{1'b0, 1'b0, 2'd0, 5'h00, 8'h96, 8'hE7, 8'h18, 3'b000, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] addr = '0;
    logic [1:0] chip_addr = '0;
    logic       rw = 1'b0;
    logic [7:0] wdata = '0;
    logic       crc_en = 1'b0;
    logic       busy, done, crc_err, sclk, mosi, cs_n;
    logic [7:0] rdata, diag0, diag1;
    logic       miso;

    int checks = 0;
    int errors = 0;

    logic [23:0] resp_word = '0;
    logic [23:0] sl_sr = '0;
    logic [23:0] mosi_cap = '0;
    int          rise_cnt = 0;
    int          frames = 0;

    logic [7:0] m_rdata = '0, m_diag0 = '0, m_diag1 = '0;
    logic       m_err = 1'b0;

    always #2 clk = ~clk;

    spi_regframe_ctrl i_spi_regframe_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .chip_addr(chip_addr),
        .rw(rw), .wdata(wdata), .crc_en(crc_en), .busy(busy), .done(done),
        .rdata(rdata), .diag0(diag0), .diag1(diag1), .crc_err(crc_err),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // device model: presents the response, records the command
    always @(negedge cs_n) begin
        sl_sr    = resp_word;
        mosi_cap = '0;
        rise_cnt = 0;
        frames++;
    end
    always @(posedge sclk) if (!cs_n) begin
        mosi_cap = {mosi_cap[22:0], mosi};
        rise_cnt++;
    end
    always @(negedge sclk) if (!cs_n) sl_sr = {sl_sr[22:0], 1'b0};
    assign miso = sl_sr[23];

    function automatic logic [4:0] crc_step(input logic [4:0] s, input logic b);
        logic [4:0] sh;
        sh = {s[3:0], 1'b0};
        return (b ^ s[4]) ? (5'h15 ^ sh) : sh;
    endfunction

    function automatic logic [4:0] crc_calc(input logic [15:0] bits, input int n);
        logic [4:0] s;
        s = 5'h1F;
        for (int i = n-1; i >= 0; i--) s = crc_step(s, bits[i]);
        for (int i = 0; i < 3; i++) s = crc_step(s, 1'b0);
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (done !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) check({req, " timeout"}, 32'd0, 32'd1);
    endtask

    task automatic run_vec(input vec_t v);
        logic [7:0]  cmd;
        logic [4:0]  rcrc;
        logic [4:0]  tcrc;
        logic [23:0] exp_tx;
        int          nb;
        cmd  = {v.chip, v.addr, v.rw};
        tcrc = crc_calc({cmd, v.wdata}, 16);
        rcrc = crc_calc({v.r0[5:0], v.r1}, 14);
        if (v.bad) rcrc = rcrc ^ 5'h01;
        nb   = v.crc_en ? 24 : 16;
        exp_tx = v.crc_en ? {cmd, v.wdata, 3'b000, tcrc} : {8'h00, cmd, v.wdata};
        @(negedge clk);
        addr = v.addr; chip_addr = v.chip; rw = v.rw; wdata = v.wdata; crc_en = v.crc_en;
        resp_word = v.crc_en ? {v.r0, v.r1, v.r2hi, rcrc} : {v.r0, v.r1, 8'h00};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", {31'd0, busy}, 32'd1);
        check("R5 cs_n low in frame", {31'd0, cs_n}, 32'd0);
        wait_done("R9");
        if (!v.bad) begin
            m_diag0 = v.r0;
            if (v.rw) m_diag1 = v.r1; else m_rdata = v.r1;
        end
        m_err = v.bad;
        check("R3 rising edges", rise_cnt, nb);
        check("R2 R4 mosi frame", {8'h00, mosi_cap}, {8'h00, exp_tx});
        check("R9 cs_n high at done", {31'd0, cs_n}, 32'd1);
        check("R6 diag0", diag0, m_diag0);
        check("R7 diag1", diag1, m_diag1);
        check("R7 rdata", rdata, m_rdata);
        check("R8 R11 crc_err", {31'd0, crc_err}, {31'd0, m_err});
        @(negedge clk);
        check("R9 done one cycle", {31'd0, done}, 32'd0);
        check("R9 idle after done", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog R9: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 cs_n", {31'd0, cs_n}, 32'd1);
        check("R1 sclk", {31'd0, sclk}, 32'd0);
        check("R1 mosi", {31'd0, mosi}, 32'd0);
        check("R1 busy/done/err", {29'd0, busy, done, crc_err}, 32'd0);
        check("R1 data outs", {8'h00, rdata, diag0, diag1}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: start raised in the done cycle is dropped
        @(negedge clk);
        addr = 5'h03; chip_addr = 2'd1; rw = 1'b1; wdata = 8'h3E; crc_en = 1'b0;
        resp_word = {8'h5C, 8'hA3, 8'h00};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10");
        f0 = frames;
        start = 1'b1;
        addr = 5'h1E;
        @(negedge clk);
        start = 1'b0;
        check("R10 start at done ignored busy", {31'd0, busy}, 32'd0);
        repeat (4) @(negedge clk);
        check("R10 no extra frame", frames, f0);
        check("R10 cs_n stays high", {31'd0, cs_n}, 32'd1);
        m_diag0 = 8'h5C; m_diag1 = 8'hA3;

        // R10: start during the frame does not alter it
        @(negedge clk);
        addr = 5'h12; chip_addr = 2'd3; rw = 1'b0; wdata = 8'hC0; crc_en = 1'b1;
        resp_word = {8'h44, 8'h99, 3'b000, crc_calc({6'h04, 8'h99}, 14)};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        f0 = frames;
        repeat (20) @(negedge clk);
        addr = 5'h01; chip_addr = 2'd0; rw = 1'b1; wdata = 8'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10");
        check("R10 frame unchanged", {8'h00, mosi_cap},
              {8'h00, 8'hE4, 8'hC0, 3'b000, crc_calc({8'hE4, 8'hC0}, 16)});
        check("R10 single frame", frames, f0);
        check("R7 read after ignored start", rdata, 8'h99);
        check("R6 diag0 after ignored start", diag0, 8'h44);
        check("R11 no crc error", {31'd0, crc_err}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule